// File: doc/BRIEF.md
# Prioritized Interrupt Level and Vector Controller

This block stands between the interrupt sources of a system and the processor core. Seven request lines are folded into a 3-bit priority level, either by a built-in priority encoder or by treating the low lines as a level that an outside encoder has already produced. The level is brought into the clock domain and filtered. It is then compared with the interrupt mask in the core's status state. When the level beats the mask, or is the non-maskable top level, the block raises an exception request toward the core.

When the core accepts the request, the block raises the mask to the accepted level and sets supervisor state. It then waits for the outcome of the acknowledge cycle, which the bus side of the system runs. There are three outcomes: a device supplies its own vector, the autovector is asked for, or nothing answers and the spurious vector is used. The chosen vector number and its table byte address go to the core on a second stream. The core can also load the mask and the supervisor bit directly, for example when it returns from a handler.

Both core-facing streams follow valid/ready rules. Once `exc_valid` or `vec_valid` is high it stays high, with its payload unchanged, until a cycle in which the matching ready is high. The transfer happens on that edge. A ready that arrives while valid is low has no effect.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset `exc_valid`, `vec_valid` and `iack_busy` are 0, `sr_mask` is 7 and `sr_super` is 1.
- R2: With the encoder enabled, the level is the position plus one of the highest set bit of `req_lines` (bit 0 is level 1 and bit 6 is level 7). All lines clear gives level 0, which means no request.
- R3: A level is only evaluated after it has shown the same value on two consecutive synchronized samples. A request one cycle long never raises `exc_valid`.
- R4: A nonzero level L raises `exc_valid` with `exc_level` = L only when L is greater than `sr_mask`. A level equal to or below the mask is not taken.
- R5: Level 7 is taken whatever the mask holds, including a mask of 7.
- R6: While `exc_valid` is high and `exc_ready` is low, `exc_valid` stays high and `exc_level` is unchanged, even if the requests change.
- R7: On the edge where `exc_valid` and `exc_ready` are both high, `sr_mask` becomes the accepted level and `sr_super` becomes 1. This takes precedence over a mask write in the same cycle, and `iack_busy` rises.
- R8: While `iack_busy` is high, `dev_vec_valid` makes the vector number equal to `dev_vec`. It wins over `auto_ack` and `no_ack` in the same cycle.
- R9: When `auto_ack` arrives without a device vector, the vector number is 24 plus the accepted level, giving 25 to 31.
- R10: When `no_ack` arrives alone, the vector number is the spurious vector 24.
- R11: `vec_addr` equals `vec_num` times 4. While `vec_valid` is high and `vec_ready` is low, both are held. After the vector transfer the block returns to idle.
- R12: A cycle with `sr_wr` high and no exception transfer loads `sr_mask` from `sr_wr_mask` and `sr_super` from `sr_wr_super`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_lines | input | 7 | Interrupt request lines, bit i is level i+1 |
| exc_valid | output | 1 | Exception request to the core |
| exc_ready | input | 1 | Core accepts the exception request |
| exc_level | output | 3 | Level of the pending or accepted interrupt |
| iack_busy | output | 1 | Waiting for the acknowledge outcome |
| dev_vec_valid | input | 1 | Device supplied a vector number |
| dev_vec | input | 8 | Device vector number |
| auto_ack | input | 1 | Acknowledge asks for the autovector |
| no_ack | input | 1 | No device answered the acknowledge |
| vec_valid | output | 1 | Vector result valid |
| vec_ready | input | 1 | Core takes the vector result |
| vec_num | output | 8 | Vector number |
| vec_addr | output | 10 | Vector table byte address |
| sr_wr | input | 1 | Core writes mask and supervisor bit |
| sr_wr_mask | input | 3 | Mask value to write |
| sr_wr_super | input | 1 | Supervisor value to write |
| sr_mask | output | 3 | Current interrupt mask |
| sr_super | output | 1 | Current supervisor state |

## Verification
The bench tests a level equal to the mask. A design that compares with greater-or-equal would take it. It also sends level 7 against a mask of 7, which a design that forgot the non-maskable case would ignore. A one-cycle request pulse checks the filter, since a design without it would raise a spurious exception. An exception transfer and a mask write in the same cycle check that the mask ends at the accepted level. Requests are dropped while the core stalls, and a design that lets the payload slip would change `exc_level` or drop valid. A device vector arriving together with an autovector request checks the priority, because a wrong order would return 24 plus the level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W    = 3;
  localparam int VEC_W    = 8;
  localparam int NUM_REQ  = (1 << LVL_W) - 1;
  localparam int AUTO_BASE = 24;
  localparam int SPUR_VEC  = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_VEC  = 2'd3
  } irq_state_e;
endpackage

// File: rtl/irq_prienc.sv
module irq_prienc #(
  parameter int NUM_REQ = 7,
  parameter int LVL_W   = 3,
  parameter bit USE_ENC = 1'b1
) (
  input  logic [NUM_REQ-1:0] req,
  output logic [LVL_W-1:0]   lvl
);
  generate
    if (USE_ENC) begin : g_enc
      always_comb begin
        lvl = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
          if (req[i]) lvl = LVL_W'(i + 1);
        end
      end
    end else begin : g_raw
      assign lvl = req[LVL_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/irq_lvlsync.sv
module irq_lvlsync #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_in,
  output logic [LVL_W-1:0] lvl_out
);
  logic [LVL_W-1:0] s1, s2, held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      held <= '0;
    end else begin
      s1 <= lvl_in;
      s2 <= s1;
      if (s1 == s2) held <= s2;
    end
  end

  assign lvl_out = held;
endmodule

// File: rtl/irq_vecsel.sv
module irq_vecsel #(
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24,
  localparam int ADDR_W   = VEC_W + 2
) (
  input  logic [LVL_W-1:0]  level,
  input  logic              dev_valid,
  input  logic [VEC_W-1:0]  dev_vec,
  input  logic              auto_ack,
  input  logic              no_ack,
  output logic              hit,
  output logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    hit = dev_valid | auto_ack | no_ack;
    if (dev_valid)     vec = dev_vec;
    else if (auto_ack) vec = VEC_W'(AUTO_BASE) + VEC_W'(level);
    else               vec = VEC_W'(SPUR_VEC);
    addr = {vec, 2'b00};
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter bit USE_ENC = 1'b1,
  localparam int ADDR_W = VEC_W + 2,
  localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_lines,
  output logic               exc_valid,
  input  logic               exc_ready,
  output logic [LVL_W-1:0]   exc_level,
  output logic               iack_busy,
  input  logic               dev_vec_valid,
  input  logic [VEC_W-1:0]   dev_vec,
  input  logic               auto_ack,
  input  logic               no_ack,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [VEC_W-1:0]   vec_num,
  output logic [ADDR_W-1:0]  vec_addr,
  input  logic               sr_wr,
  input  logic [LVL_W-1:0]   sr_wr_mask,
  input  logic               sr_wr_super,
  output logic [LVL_W-1:0]   sr_mask,
  output logic               sr_super
);
  logic [LVL_W-1:0]  raw_lvl, lvl_st, lvl_r;
  logic              take, sel_hit;
  logic [VEC_W-1:0]  sel_vec, vec_r;
  logic [ADDR_W-1:0] sel_addr, addr_r;
  irq_state_e        st;

  irq_prienc #(.NUM_REQ(NUM_REQ), .LVL_W(LVL_W), .USE_ENC(USE_ENC)) u_enc (
    .req(req_lines), .lvl(raw_lvl));

  irq_lvlsync #(.LVL_W(LVL_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .lvl_in(raw_lvl), .lvl_out(lvl_st));

  irq_vecsel #(.LVL_W(LVL_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE),
               .SPUR_VEC(SPUR_VEC)) u_vec (
    .level(lvl_r), .dev_valid(dev_vec_valid), .dev_vec(dev_vec),
    .auto_ack(auto_ack), .no_ack(no_ack),
    .hit(sel_hit), .vec(sel_vec), .addr(sel_addr));

  assign take = (lvl_st != '0) && ((lvl_st > sr_mask) || (lvl_st == NMI_LVL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      lvl_r    <= '0;
      vec_r    <= '0;
      addr_r   <= '0;
      sr_mask  <= NMI_LVL;
      sr_super <= 1'b1;
    end else begin
      if (st == ST_REQ && exc_ready) begin
        sr_mask  <= lvl_r;
        sr_super <= 1'b1;
      end else if (sr_wr) begin
        sr_mask  <= sr_wr_mask;
        sr_super <= sr_wr_super;
      end
      unique case (st)
        ST_IDLE: if (take) begin
          lvl_r <= lvl_st;
          st    <= ST_REQ;
        end
        ST_REQ:  if (exc_ready) st <= ST_ACK;
        ST_ACK:  if (sel_hit) begin
          vec_r  <= sel_vec;
          addr_r <= sel_addr;
          st     <= ST_VEC;
        end
        ST_VEC:  if (vec_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign exc_valid = (st == ST_REQ);
  assign exc_level = lvl_r;
  assign iack_busy = (st == ST_ACK);
  assign vec_valid = (st == ST_VEC);
  assign vec_num   = vec_r;
  assign vec_addr  = addr_r;
endmodule

// File: rtl/irq_level_chk.sv
module irq_level_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exc_valid,
  input logic       exc_ready,
  input logic [2:0] exc_level,
  input logic       iack_busy,
  input logic       vec_valid,
  input logic       vec_ready,
  input logic [7:0] vec_num,
  input logic [9:0] vec_addr,
  input logic [2:0] sr_mask,
  input logic       sr_super
);
  AST_LEVEL_BEATS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_valid) |-> (exc_level > $past(sr_mask)) || (exc_level == 3'd7)); // R4
  AST_NONZERO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> exc_level != 3'd0); // R2
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !exc_ready |=> exc_valid && $stable(exc_level)); // R6
  AST_TAKE_UPDATES_SR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_ready |=> sr_super && (sr_mask == $past(exc_level)) && iack_busy); // R7
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_num) && $stable(vec_addr)); // R11
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_valid, iack_busy, vec_valid})); // R11
endmodule

bind irq_level_ctrl irq_level_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_ready(exc_ready),
  .exc_level(exc_level), .iack_busy(iack_busy), .vec_valid(vec_valid),
  .vec_ready(vec_ready), .vec_num(vec_num), .vec_addr(vec_addr),
  .sr_mask(sr_mask), .sr_super(sr_super));

// File: tb/irq_level_ctrl_bench.sv
`timescale 1ns/1ps
module irq_level_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] req_lines = '0;
  logic       exc_valid, exc_ready = 1'b0;
  logic [2:0] exc_level;
  logic       iack_busy;
  logic       dev_vec_valid = 1'b0;
  logic [7:0] dev_vec = '0;
  logic       auto_ack = 1'b0, no_ack = 1'b0;
  logic       vec_valid, vec_ready = 1'b0;
  logic [7:0] vec_num;
  logic [9:0] vec_addr;
  logic       sr_wr = 1'b0;
  logic [2:0] sr_wr_mask = '0;
  logic       sr_wr_super = 1'b0;
  logic [2:0] sr_mask;
  logic       sr_super;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_level_ctrl u_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .req_lines(req_lines),
    .exc_valid(exc_valid), .exc_ready(exc_ready), .exc_level(exc_level),
    .iack_busy(iack_busy), .dev_vec_valid(dev_vec_valid), .dev_vec(dev_vec),
    .auto_ack(auto_ack), .no_ack(no_ack), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_num(vec_num), .vec_addr(vec_addr),
    .sr_wr(sr_wr), .sr_wr_mask(sr_wr_mask), .sr_wr_super(sr_wr_super),
    .sr_mask(sr_mask), .sr_super(sr_super));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_sr(input logic [2:0] m, input logic s);
    sr_wr = 1'b1; sr_wr_mask = m; sr_wr_super = s;
    step();
    sr_wr = 1'b0;
    chk("R12 mask write", sr_mask, m);
    chk("R12 super write", sr_super, s);
  endtask

  task automatic wait_exc(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 12 && !seen; i++) begin
      step();
      if (exc_valid) seen = 1'b1;
    end
  endtask

  task automatic accept_exc();
    exc_ready = 1'b1;
    step();
    exc_ready = 1'b0;
  endtask

  task automatic finish_vec();
    vec_ready = 1'b1;
    step();
    vec_ready = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 exc_valid", exc_valid, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 iack_busy", iack_busy, 0);
    chk("R1 mask", sr_mask, 7);
    chk("R1 super", sr_super, 1);
  endtask

  task automatic t_mask_and_auto();
    bit seen;
    write_sr(3'd3, 1'b0);
    req_lines = 7'b0000100;                   // level 3, equal to mask
    wait_exc(seen);
    chk("R4 equal level not taken", seen, 0);
    req_lines = 7'b0001000;                   // level 4
    wait_exc(seen);
    chk("R4 higher level taken", seen, 1);
    chk("R4 level", exc_level, 4);
    req_lines = '0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R6 valid held", exc_valid, 1);
      chk("R6 level held", exc_level, 4);
    end
    accept_exc();
    chk("R7 mask takes level", sr_mask, 4);
    chk("R7 super set", sr_super, 1);
    chk("R7 iack busy", iack_busy, 1);
    auto_ack = 1'b1;
    step();
    auto_ack = 1'b0;
    chk("R9 vec valid", vec_valid, 1);
    chk("R9 autovector", vec_num, 28);
    chk("R11 address", vec_addr, 112);
    step(); step();
    chk("R11 vec held", vec_valid, 1);
    chk("R11 vec num held", vec_num, 28);
    finish_vec();
    chk("R11 back to idle", vec_valid | exc_valid | iack_busy, 0);
  endtask

  task automatic t_encoder();
    bit seen;
    write_sr(3'd0, 1'b0);
    req_lines = 7'b0010110;                   // levels 2,3,5 active
    wait_exc(seen);
    chk("R2 taken", seen, 1);
    chk("R2 highest line", exc_level, 5);
    req_lines = '0;
    accept_exc();
    no_ack = 1'b1;
    step();
    no_ack = 1'b0;
    chk("R10 spurious vector", vec_num, 24);
    chk("R10 spurious address", vec_addr, 96);
    finish_vec();
    write_sr(3'd0, 1'b0);
    req_lines = 7'b0000001;
    wait_exc(seen);
    chk("R2 lowest line level", exc_level, 1);
    req_lines = '0;
    accept_exc();
    auto_ack = 1'b1;
    step();
    auto_ack = 1'b0;
    chk("R9 level one autovector", vec_num, 25);
    finish_vec();
  endtask

  task automatic t_glitch();
    bit seen;
    write_sr(3'd0, 1'b0);
    req_lines = 7'b0100000;                   // level 6 for one cycle
    step();
    req_lines = '0;
    wait_exc(seen);
    chk("R3 one-cycle pulse ignored", seen, 0);
  endtask

  task automatic t_nmi_and_dev();
    bit seen;
    write_sr(3'd7, 1'b0);
    req_lines = 7'b1000000;                   // level 7
    wait_exc(seen);
    chk("R5 level 7 through mask 7", seen, 1);
    chk("R5 level", exc_level, 7);
    req_lines = '0;
    accept_exc();
    chk("R7 super after nmi", sr_super, 1);
    dev_vec_valid = 1'b1; dev_vec = 8'h40; auto_ack = 1'b1;
    step();
    dev_vec_valid = 1'b0; auto_ack = 1'b0;
    chk("R8 device vector wins", vec_num, 64);
    chk("R11 device address", vec_addr, 256);
    finish_vec();
  endtask

  task automatic t_precedence();
    bit seen;
    write_sr(3'd1, 1'b0);
    req_lines = 7'b0000100;                   // level 3
    wait_exc(seen);
    chk("R4 level 3 over mask 1", exc_level, 3);
    req_lines = '0;
    sr_wr = 1'b1; sr_wr_mask = 3'd0; sr_wr_super = 1'b0;
    accept_exc();
    sr_wr = 1'b0;
    chk("R7 accept beats write mask", sr_mask, 3);
    chk("R7 accept beats write super", sr_super, 1);
    no_ack = 1'b1;
    step();
    no_ack = 1'b0;
    finish_vec();
  endtask

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_mask_and_auto();
    t_encoder();
    t_glitch();
    t_nmi_and_dev();
    t_precedence();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule